// File: doc/BRIEF.md
# Compact Eight-Bit VM Instruction Core

This block is a multi-cycle sequencer for a small virtual machine whose instructions are 16 bits wide. It holds sixteen 8-bit data registers, a 12-bit index register, a 12-bit program counter and a return-address stack. Each instruction is read as two bytes over a byte-wide request/response memory port. The top nibble of the instruction selects its class. The core then runs it in a single execute cycle.

Two opcodes need the frame buffer: clear-screen and sprite draw. For these the core does not touch the display itself. It hands the operands to an external display engine and waits for that engine to report completion. A draw can report a pixel collision, and the core stores that result in the last data register (VF). The core supports jumps, calls and returns, conditional skips, immediate loads and adds, register copy, index load and offset jump. Every other opcode completes as a no-op.

Port rules:

- **Memory request.** The request side is valid/ready. Once `mem_req_valid` is raised, it stays high with a stable address until `mem_req_ready` accepts it.
- **Memory response.** The core has at most one request outstanding and is always able to take the response. There is therefore no ready on the response side. The memory must return exactly one `mem_rsp_valid` pulse per accepted request.
- **Display handshake.** `disp_start` and the display operands are held until a one-cycle `disp_done` pulse arrives.

Top module: `vm_core`

## Requirements
- R1: After reset, PC is 0x200, the stack pointer and all data, index and stack registers are 0. The first memory request asks for address 0x200, and `disp_start` is low.
- R2: An instruction is fetched as two requests: the high byte at PC, then the low byte at PC+1. The instruction is {high, low}. PC advances by 2 (modulo 4096) before the instruction executes. A request with ready low is held unchanged, and no new request is raised while a response is outstanding.
- R3: Any opcode not named in R4 to R11 has no effect beyond the PC advance. This covers classes 0x0 other than 00E0/00EE, and classes 0xC, 0xE and 0xF.
- R4: 1nnn sets PC to nnn. Bnnn sets PC to (nnn + V0) modulo 4096.
- R5: 2nnn writes the advanced PC to stack[SP], increments SP, and jumps to nnn. 00EE decrements SP and loads PC from stack[SP]. The stack has 16 entries, and SP wraps silently in both directions.
- R6: 3xkk skips the next instruction (PC += 2) when VX equals kk. 4xkk skips when VX differs from kk.
- R7: 5xyN skips when VX equals VY. 9xyN skips when they differ. The low nibble N is ignored.
- R8: 6xkk loads kk into VX. 7xkk adds kk to VX modulo 256 and leaves VF unchanged unless X is 15.
- R9: 8xy0 copies VY into VX. Class 0x8 with a nonzero low nibble is a no-op.
- R10: Annn loads nnn into the index register, which is presented on `disp_index`.
- R11: For 00E0 (`disp_op`=0) and Dxyn (`disp_op`=1), the core raises `disp_start` with the operands VX, VY, n and I. It holds all of them stable until `disp_done`, and makes no memory request until after done.
- R12: When a draw completes, VF takes the value of `disp_collision`. A clear leaves VF unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req_valid | output | 1 | Byte read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 12 | Byte address of the request |
| mem_rsp_valid | input | 1 | Read data valid, one pulse per accepted request |
| mem_rsp_data | input | 8 | Read data byte |
| disp_start | output | 1 | Display command pending, held until done |
| disp_op | output | 1 | 0 = clear screen, 1 = sprite draw |
| disp_x | output | 8 | VX value for the draw |
| disp_y | output | 8 | VY value for the draw |
| disp_n | output | 4 | Sprite row count |
| disp_index | output | 12 | Index register (sprite source address) |
| disp_done | input | 1 | Display command finished, one-cycle pulse |
| disp_collision | input | 1 | Collision result, valid with done |

## Verification
The assertions take for granted three things about the neighbours:

- The memory answers each accepted request exactly once and never sends a response on its own.
- The display engine pulses `disp_done` only while `disp_start` is high.
- Done lasts one cycle.

The stimulus keeps to these rules by modelling both neighbours inside the bench. Ready gaps, read latencies and done delays come from a rotating pattern. The engine reports a collision on alternate commands, including on a clear, where the core must ignore it.

// File: rtl/vm_core_pkg.sv
package vm_core_pkg;

  localparam int VM_AW     = 12;
  localparam int VM_DW     = 8;
  localparam int VM_NREG   = 16;
  localparam int VM_REG_AW = $clog2(VM_NREG);

  typedef enum logic [2:0] {
    ST_REQ_HI,
    ST_WAIT_HI,
    ST_REQ_LO,
    ST_WAIT_LO,
    ST_EXEC,
    ST_DISP
  } state_e;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_CLS,
    OP_RET,
    OP_JP,
    OP_CALL,
    OP_SEQ_IMM,
    OP_SNE_IMM,
    OP_SEQ_REG,
    OP_SNE_REG,
    OP_LD_IMM,
    OP_ADD_IMM,
    OP_MOV,
    OP_LDI,
    OP_JP_OFF,
    OP_DRAW
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [3:0] x;
    logic [3:0] y;
    logic [3:0] n;
    logic [7:0] kk;
    logic [11:0] nnn;
  } dec_t;

endpackage

// File: rtl/vm_decode.sv
module vm_decode
  import vm_core_pkg::*;
(
  input  logic [15:0] instr,
  output dec_t        dec
);

  always_comb begin
    dec.x   = instr[11:8];
    dec.y   = instr[7:4];
    dec.n   = instr[3:0];
    dec.kk  = instr[7:0];
    dec.nnn = instr[11:0];
    dec.op  = OP_NOP;
    case (instr[15:12])
      4'h0: begin
        if (instr == 16'h00E0)      dec.op = OP_CLS;
        else if (instr == 16'h00EE) dec.op = OP_RET;
      end
      4'h1: dec.op = OP_JP;
      4'h2: dec.op = OP_CALL;
      4'h3: dec.op = OP_SEQ_IMM;
      4'h4: dec.op = OP_SNE_IMM;
      4'h5: dec.op = OP_SEQ_REG;
      4'h6: dec.op = OP_LD_IMM;
      4'h7: dec.op = OP_ADD_IMM;
      4'h8: if (instr[3:0] == 4'h0) dec.op = OP_MOV;
      4'h9: dec.op = OP_SNE_REG;
      4'hA: dec.op = OP_LDI;
      4'hB: dec.op = OP_JP_OFF;
      4'hD: dec.op = OP_DRAW;
      default: dec.op = OP_NOP;
    endcase
  end

endmodule

// File: rtl/vm_regfile.sv
module vm_regfile #(
  parameter  int NREG = 16,
  parameter  int DW   = 8,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_addr,
  input  logic [AW-1:0] rd_b_addr,
  output logic [DW-1:0] rd_a_data,
  output logic [DW-1:0] rd_b_data,
  output logic [DW-1:0] rd_zero_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else if (wr_en) begin
      regs[wr_addr] <= wr_data;
    end
  end

  assign rd_a_data    = regs[rd_a_addr];
  assign rd_b_data    = regs[rd_b_addr];
  assign rd_zero_data = regs[0];

endmodule

// File: rtl/vm_call_stack.sv
module vm_call_stack #(
  parameter  int DEPTH = 16,
  parameter  int DW    = 12,
  localparam int SPW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] top_data
);

  logic [SPW-1:0] sp;
  logic [SPW-1:0] sp_dec;
  logic [DW-1:0]  slots [DEPTH];

  assign sp_dec   = sp - SPW'(1);
  assign top_data = slots[sp_dec];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int k = 0; k < DEPTH; k++) slots[k] <= '0;
    end else if (push) begin
      slots[sp] <= push_data;
      sp        <= sp + SPW'(1);
    end else if (pop) begin
      sp <= sp_dec;
    end
  end

endmodule

// File: rtl/vm_core.sv
module vm_core
  import vm_core_pkg::*;
#(
  parameter logic [11:0] RESET_PC    = 12'h200,
  parameter int          STACK_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [11:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [7:0]  mem_rsp_data,
  output logic        disp_start,
  output logic        disp_op,
  output logic [7:0]  disp_x,
  output logic [7:0]  disp_y,
  output logic [3:0]  disp_n,
  output logic [11:0] disp_index,
  input  logic        disp_done,
  input  logic        disp_collision
);

  localparam logic [VM_REG_AW-1:0] FLAG_REG = VM_REG_AW'(VM_NREG - 1);

  state_e            st;
  logic [VM_AW-1:0]  pc;
  logic [VM_AW-1:0]  idx;
  logic [VM_DW-1:0]  hi_q;
  logic [15:0]       ir;
  dec_t              d;

  logic [VM_DW-1:0]  vx, vy, v0;
  logic              rf_we;
  logic [VM_REG_AW-1:0] rf_wa;
  logic [VM_DW-1:0]  rf_wd;
  logic              stk_push, stk_pop;
  logic [VM_AW-1:0]  stk_top;
  logic [VM_AW-1:0]  pc_skip;

  vm_decode u_dec (
    .instr (ir),
    .dec   (d)
  );

  vm_regfile #(.NREG(VM_NREG), .DW(VM_DW)) u_rf (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_a_addr    (d.x),
    .rd_b_addr    (d.y),
    .rd_a_data    (vx),
    .rd_b_data    (vy),
    .rd_zero_data (v0),
    .wr_en        (rf_we),
    .wr_addr      (rf_wa),
    .wr_data      (rf_wd)
  );

  vm_call_stack #(.DEPTH(STACK_DEPTH), .DW(VM_AW)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (stk_push),
    .pop       (stk_pop),
    .push_data (pc),
    .top_data  (stk_top)
  );

  assign pc_skip = pc + VM_AW'(2);

  // Register-file write port and stack control
  always_comb begin
    rf_we    = 1'b0;
    rf_wa    = d.x;
    rf_wd    = d.kk;
    stk_push = 1'b0;
    stk_pop  = 1'b0;
    if (st == ST_EXEC) begin
      case (d.op)
        OP_LD_IMM:  rf_we = 1'b1;
        OP_ADD_IMM: begin rf_we = 1'b1; rf_wd = vx + d.kk; end
        OP_MOV:     begin rf_we = 1'b1; rf_wd = vy; end
        OP_CALL:    stk_push = 1'b1;
        OP_RET:     stk_pop = 1'b1;
        default: ;
      endcase
    end else if (st == ST_DISP && disp_done && d.op == OP_DRAW) begin
      rf_we = 1'b1;
      rf_wa = FLAG_REG;
      rf_wd = {{(VM_DW-1){1'b0}}, disp_collision};
    end
  end

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_REQ_HI;
      pc   <= RESET_PC;
      idx  <= '0;
      hi_q <= '0;
      ir   <= '0;
    end else begin
      case (st)
        ST_REQ_HI:  if (mem_req_ready) st <= ST_WAIT_HI;
        ST_WAIT_HI: if (mem_rsp_valid) begin
          hi_q <= mem_rsp_data;
          st   <= ST_REQ_LO;
        end
        ST_REQ_LO:  if (mem_req_ready) st <= ST_WAIT_LO;
        ST_WAIT_LO: if (mem_rsp_valid) begin
          ir <= {hi_q, mem_rsp_data};
          pc <= pc_skip;
          st <= ST_EXEC;
        end
        ST_EXEC: begin
          st <= ST_REQ_HI;
          case (d.op)
            OP_JP, OP_CALL: pc <= d.nnn;
            OP_RET:         pc <= stk_top;
            OP_SEQ_IMM:     if (vx == d.kk) pc <= pc_skip;
            OP_SNE_IMM:     if (vx != d.kk) pc <= pc_skip;
            OP_SEQ_REG:     if (vx == vy)   pc <= pc_skip;
            OP_SNE_REG:     if (vx != vy)   pc <= pc_skip;
            OP_LDI:         idx <= d.nnn;
            OP_JP_OFF:      pc <= d.nnn + {{(VM_AW-VM_DW){1'b0}}, v0};
            OP_CLS, OP_DRAW: st <= ST_DISP;
            default: ;
          endcase
        end
        ST_DISP: if (disp_done) st <= ST_REQ_HI;
        default: st <= ST_REQ_HI;
      endcase
    end
  end

  assign mem_req_valid = (st == ST_REQ_HI) || (st == ST_REQ_LO);
  assign mem_req_addr  = (st == ST_REQ_LO) ? pc + VM_AW'(1) : pc;

  assign disp_start = (st == ST_DISP);
  assign disp_op    = (d.op == OP_DRAW);
  assign disp_x     = vx;
  assign disp_y     = vy;
  assign disp_n     = d.n;
  assign disp_index = idx;

endmodule

// File: rtl/vm_core_chk.sv
module vm_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [11:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        disp_start,
  input logic        disp_op,
  input logic [7:0]  disp_x,
  input logic [7:0]  disp_y,
  input logic [3:0]  disp_n,
  input logic [11:0] disp_index,
  input logic        disp_done
);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R2
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R2
  rsp_while_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid);

  // R11
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_start && !disp_done |=> disp_start);

  // R11
  disp_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_start && !disp_done |=>
      $stable({disp_op, disp_x, disp_y, disp_n, disp_index}));

  // R11
  disp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(disp_start && mem_req_valid));

  // R11
  disp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_start && disp_done |=> !disp_start);

endmodule

bind vm_core vm_core_chk u_chk (.*);

// File: tb/tb_vm_core.sv
module tb_vm_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [11:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = 8'h00;
  logic        disp_start;
  logic        disp_op;
  logic [7:0]  disp_x, disp_y;
  logic [3:0]  disp_n;
  logic [11:0] disp_index;
  logic        disp_done = 1'b0;
  logic        disp_collision = 1'b0;

  vm_core dut (.*);

  always #5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;

  // reference model state
  logic [7:0] mem [4096];
  int mpc, mi, msp;
  int mv  [16];
  int mstk[16];
  string tag;
  bit    dpend;
  int    e_op, e_x, e_y, e_n, e_i;

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic put16(int a, int w);
    mem[a]            = 8'((w >> 8) & 255);
    mem[(a + 1) % 4096] = 8'(w & 255);
  endtask

  task automatic model_exec(int ins);
    int top = (ins >> 12) & 15;
    int x = (ins >> 8) & 15;
    int y = (ins >> 4) & 15;
    int n = ins & 15;
    int kk = ins & 255;
    int nnn = ins & 4095;
    mpc = (mpc + 2) % 4096;
    tag = "R2";
    case (top)
      0: begin
        if (ins == 16'h00E0) begin
          dpend = 1; e_op = 0; e_x = mv[x]; e_y = mv[y]; e_n = n; e_i = mi; tag = "R11";
        end else if (ins == 16'h00EE) begin
          msp = (msp + 15) % 16; mpc = mstk[msp]; tag = "R5";
        end else tag = "R3";
      end
      1: begin mpc = nnn; tag = "R4"; end
      2: begin mstk[msp] = mpc; msp = (msp + 1) % 16; mpc = nnn; tag = "R5"; end
      3: begin if (mv[x] == kk) mpc = (mpc + 2) % 4096; tag = "R6"; end
      4: begin if (mv[x] != kk) mpc = (mpc + 2) % 4096; tag = "R6"; end
      5: begin if (mv[x] == mv[y]) mpc = (mpc + 2) % 4096; tag = "R7"; end
      9: begin if (mv[x] != mv[y]) mpc = (mpc + 2) % 4096; tag = "R7"; end
      6: begin mv[x] = kk; tag = "R8"; end
      7: begin mv[x] = (mv[x] + kk) % 256; tag = "R8"; end
      8: begin if (n == 0) mv[x] = mv[y]; tag = "R9"; end
      10: begin mi = nnn; tag = "R10"; end
      11: begin mpc = (nnn + mv[0]) % 4096; tag = "R4"; end
      13: begin
        dpend = 1; e_op = 1; e_x = mv[x]; e_y = mv[y]; e_n = n; e_i = mi; tag = "R11";
      end
      default: tag = "R3";
    endcase
  endtask

  initial begin
    int cyc = 0;
    int rsp_cnt = 0;
    bit rsp_lo = 0;
    bit want_lo = 0;
    int rsp_addr = 0;
    int hi_b = 0;
    int retired = 0;
    bit in_disp = 0;
    int disp_cnt = 0;
    int ncmd = 0;
    bit coll = 0;

    for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
    // main program
    put16(12'h200, 16'h6A12); put16(12'h202, 16'h6B34);
    put16(12'h204, 16'hA123); put16(12'h206, 16'hDAB5);
    put16(12'h208, 16'h7AFF); put16(12'h20A, 16'hDAF3);
    put16(12'h20C, 16'h00E0); put16(12'h20E, 16'hDFF1);
    put16(12'h210, 16'h8CA0); put16(12'h212, 16'h8DA1);
    put16(12'h214, 16'hDCD2); put16(12'h216, 16'h3C11);
    put16(12'h218, 16'h6C00); put16(12'h21A, 16'h4C11);
    put16(12'h21C, 16'h5CA0); put16(12'h21E, 16'h6C00);
    put16(12'h220, 16'h9CA0); put16(12'h222, 16'h9CB0);
    put16(12'h224, 16'h6C00); put16(12'h226, 16'h5CB0);
    put16(12'h228, 16'hF123); put16(12'h22A, 16'h0123);
    put16(12'h22C, 16'h2300); put16(12'h22E, 16'h1240);
    put16(12'h300, 16'h2310); put16(12'h302, 16'h00EE);
    put16(12'h310, 16'hDCA4); put16(12'h312, 16'h00EE);
    put16(12'h240, 16'h6005); put16(12'h242, 16'hB250);
    put16(12'h255, 16'h60FF); put16(12'h257, 16'hBFFF);
    put16(12'h0FE, 16'h1400);
    // deep call chain that wraps the 16-entry stack, then returns
    for (int k = 0; k < 17; k++) put16(12'h400 + 2 * k, 16'h2402 + 2 * k);
    put16(12'h422, 16'h00EE);

    mpc = 12'h200; mi = 0; msp = 0; dpend = 0; tag = "R1";
    for (int k = 0; k < 16; k++) begin mv[k] = 0; mstk[k] = 0; end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        chk("R1", "first request valid", int'(mem_req_valid), 1);
        chk("R1", "first request address", int'(mem_req_addr), 12'h200);
        chk("R1", "disp_start after reset", int'(disp_start), 0);
      end
      // memory response lane
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[rsp_addr];
          if (rsp_lo) begin
            model_exec(hi_b * 256 + int'(mem[rsp_addr]));
            retired++;
          end else hi_b = int'(mem[rsp_addr]);
        end
      end
      // display engine lane
      if (disp_done) disp_done = 1'b0;
      if (in_disp) begin
        if (disp_cnt == 0) begin
          coll = (ncmd % 2) == 0;
          disp_done = 1'b1;
          disp_collision = coll;
          if (e_op == 1) mv[15] = int'(coll);
          in_disp = 0; dpend = 0; ncmd++;
        end else disp_cnt--;
      end else if (disp_start) begin
        chk("R11", "unexpected disp_start", int'(dpend), 1);
        chk("R11", "disp_op", int'(disp_op), e_op);
        chk("R11", "disp_n", int'(disp_n), e_n);
        chk("R8 R9 R12", "disp_x", int'(disp_x), e_x);
        chk("R8 R9 R12", "disp_y", int'(disp_y), e_y);
        chk("R10", "disp_index", int'(disp_index), e_i);
        in_disp = 1; disp_cnt = cyc % 4;
      end
      // memory request lane
      mem_req_ready = (cyc % 3) != 1;
      if (mem_req_valid) begin
        chk("R11", "fetch while display pending", int'(dpend), 0);
        chk("R2", "request while response outstanding", int'(rsp_cnt > 0 || mem_rsp_valid), 0);
        if (mem_req_ready) begin
          chk(tag, want_lo ? "low byte address" : "high byte address",
              int'(mem_req_addr), want_lo ? (mpc + 1) % 4096 : mpc);
          rsp_addr = int'(mem_req_addr);
          rsp_lo   = want_lo;
          want_lo  = !want_lo;
          rsp_cnt  = 1 + (cyc % 3);
        end
      end
      if (retired >= 150 && !in_disp && !dpend && rsp_cnt == 0) break;
      if (cyc > 60000) begin
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=%0d expected=<60000", cyc);
        break;
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule